// File: doc/BRIEF.md
# Phase-Toggling Block Transfer Engine

This engine sits on the host side of a parallel-port-to-disk bridge. It moves a counted run of bytes between a local byte stream and the bridge. It emits one port operation per cycle: a data-port write, a control-port write, an address-cycle write, a data-cycle write, or a read of one of the port's inputs. Three legacy transfer styles are supported: nibble reads, 5/3 split reads and full byte reads. In these styles the engine flips a phase bit in the control value for every byte. Three address/data-cycle styles move 8-, 16- or 32-bit units. For these the engine may wrap the run in writes to a block-size control register. It places those writes on a shared configuration request port.

A transfer starts with a one-cycle `start` pulse. The direction, mode code and byte count are latched on that pulse. While a transfer is running, `start` is ignored. Mode codes 6 and 7 are also ignored.

Outgoing bytes come from a valid/ready source stream. A byte moves on any clock edge where `wr_valid` and `wr_ready` are both high. The engine never requires the source to hold `wr_valid`. Incoming bytes go to a valid/ready sink. Once `rd_valid` is raised, it stays high with `rd_data` unchanged until `rd_ready` is seen. Port activity stalls in both directions until the stream side moves. A configuration request (`cfg_valid`) likewise holds its value until `cfg_ready`. `done` pulses for one cycle after the last operation of the transfer.

Top module: `bte_top`

## Requirements
- R1: After reset, `port_op` is 0 (no operation), and `rd_valid`, `wr_ready`, `cfg_valid` and `done` are all low.
- R2: At most one port operation is issued per cycle. The `port_op` codes are: 0 none, 1 data-port write, 2 control write, 3 address-cycle write, 4 data-cycle write, 5 status read, 6 paired status read (`port_in_a[7:0]` and `port_in_b`), 7 data-port read, 8 data-cycle read. Read operations carry `port_val` 0. `port_op` is 0 while a configuration request is pending.
- R3: Mode 0 read.
  - Preamble: data 0x81, control 0x01, control 0x03, data 0xC1.
  - Per byte, with a phase starting at 1: control 2+ph, status read A, control 4+ph, status read B.
  - The byte delivered is {B[7:4], A[7:4]}, and the phase then flips.
  - Trailer: data 0x00, control 0x04.
- R4: Mode 1 read.
  - Preamble: data 0x91, control 0x01, data 0x10, control 0x03, data 0x51, control 0x05, data 0xD1.
  - Per byte, with the phase starting at 1: control 4+ph, then one paired read.
  - The byte delivered is {b[3:1], a[7:3]}, where a=`port_in_a[7:0]` and b=`port_in_b`.
  - Trailer: data 0x00, control 0x04.
- R5: Mode 2 read.
  - Preamble: data 0x89, control 0x01, 0x23, 0x21.
  - Per byte, with the phase starting at 1: control 0x24+ph, then a data-port read whose `port_in_a[7:0]` is the byte.
  - Trailer: control 0x06, control 0x04.
- R6: Writes in modes 0 to 2.
  - Preamble: data 0xA1, control 0x01, 0x03, 0x01, 0x05.
  - Per byte, with a phase starting at 0: a data-port write of the byte, only when it differs from the last byte written in this transfer (the first byte is always written), then control 4+ph.
  - Trailer: control 0x07, control 0x04.
- R7: Reads in modes 3 to 5.
  - A request of value 3 to register 0x84 comes first, but only when count > 512.
  - Then address 0x00, control 0x24, one data-cycle read per unit, control 0x04, and finally a request of value 0 to register 0x84.
- R8: Writes in modes 3 to 5.
  - A request of value 1 to register 0x84 comes first, and one of value 0 comes last, both only when count < 512.
  - Between them: address 0x40, then one data-cycle write per unit.
- R9: Unit width and count.
  - Mode 3 moves count units of 8 bits (`port_size` 0).
  - Mode 4 moves count/2 units of 16 bits (`port_size` 1).
  - Mode 5 moves count/4 units of 32 bits (`port_size` 2).
  - Unit bytes map to the stream least significant byte first. On writes, unused upper bits of `port_val` are 0.
- R10: Back-pressure.
  - `rd_valid` and `rd_data` hold until `rd_ready`.
  - `cfg_valid` and `cfg_data` hold until `cfg_ready`.
  - No port operation is issued while the engine waits on a stream or on the request port.
- R11: `done` is a single-cycle pulse, issued one cycle after the final operation or request of the transfer, with no port operation in that cycle.
- R12: `start` is ignored while a transfer is in progress, and ignored in idle when `mode` is 6 or 7.
- R13: A count of zero units issues the preamble, then the trailer, then `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a transfer (idle only) |
| dir_wr | input | 1 | 1: stream to port, 0: port to stream |
| mode | input | 3 | Transfer style code 0..5 |
| count | input | CNT_W | Byte count |
| done | output | 1 | End-of-transfer pulse |
| wr_valid | input | 1 | Source byte valid |
| wr_ready | output | 1 | Engine accepts source byte |
| wr_data | input | 8 | Source byte |
| rd_valid | output | 1 | Sink byte valid |
| rd_ready | input | 1 | Sink accepts byte |
| rd_data | output | 8 | Sink byte |
| port_op | output | 4 | Port operation code this cycle |
| port_val | output | 8*WORD_BYTES | Value written by the operation |
| port_size | output | 2 | Data-cycle unit size code |
| port_in_a | input | 8*WORD_BYTES | Read value (status, data or data-cycle) |
| port_in_b | input | 8 | Second read value for paired reads |
| cfg_valid | output | 1 | Size-register write request |
| cfg_ready | input | 1 | Request accepted |
| cfg_addr | output | 8 | Request register address |
| cfg_data | output | 8 | Request value |

## Verification
A wrong phase bit shows at once as an odd/even swap of the low control bit, in the first or second per-byte strobe. A stale duplicate-byte tracker shows as a missing or extra data-port write within one byte slot. A miscounted unit counter shows at the trailer, as an early or late closing control value and a `done` misplaced by whole byte slots. Lane-order or size-code faults show on the first delivered 16- or 32-bit unit as swapped bytes or a wrong `port_size`.

// File: rtl/bte_pkg.sv
package bte_pkg;

  typedef enum logic [3:0] {
    OP_NONE    = 4'd0,
    OP_WR_DATA = 4'd1,
    OP_WR_CTRL = 4'd2,
    OP_WR_ADDR = 4'd3,
    OP_WR_EPP  = 4'd4,
    OP_RD_STAT = 4'd5,
    OP_RD_PAIR = 4'd6,
    OP_RD_DATA = 4'd7,
    OP_RD_EPP  = 4'd8
  } port_op_e;

  typedef enum logic [1:0] {
    SEC_PRE  = 2'd0,
    SEC_BODY = 2'd1,
    SEC_POST = 2'd2
  } section_e;

  localparam logic [2:0] MODE_NIB  = 3'd0;
  localparam logic [2:0] MODE_53   = 3'd1;
  localparam logic [2:0] MODE_BYTE = 3'd2;
  localparam logic [2:0] MODE_W8   = 3'd3;
  localparam logic [2:0] MODE_W16  = 3'd4;
  localparam logic [2:0] MODE_W32  = 3'd5;

endpackage

// File: rtl/bte_script.sv
// Fixed per-mode operation scripts: preamble, per-byte read body, trailer.
module bte_script
  import bte_pkg::*;
(
  input  logic [2:0] mode,
  input  logic       wr,
  input  section_e   sec,
  input  logic [2:0] idx,
  input  logic       ph,
  output port_op_e   op,
  output logic [7:0] val,
  output logic       last,
  output logic       empty
);

  logic wide;
  assign wide = (mode >= MODE_W8);

  always_comb begin
    op    = OP_NONE;
    val   = 8'h00;
    last  = 1'b1;
    empty = 1'b0;
    if (!wr) begin
      unique case (sec)
        SEC_PRE: begin
          if (wide) begin
            case (idx)
              3'd0:    begin op = OP_WR_ADDR; val = 8'h00; last = 1'b0; end
              default: begin op = OP_WR_CTRL; val = 8'h24; end
            endcase
          end else if (mode == MODE_NIB) begin
            case (idx)
              3'd0:    begin op = OP_WR_DATA; val = 8'h81; last = 1'b0; end
              3'd1:    begin op = OP_WR_CTRL; val = 8'h01; last = 1'b0; end
              3'd2:    begin op = OP_WR_CTRL; val = 8'h03; last = 1'b0; end
              default: begin op = OP_WR_DATA; val = 8'hC1; end
            endcase
          end else if (mode == MODE_53) begin
            case (idx)
              3'd0:    begin op = OP_WR_DATA; val = 8'h91; last = 1'b0; end
              3'd1:    begin op = OP_WR_CTRL; val = 8'h01; last = 1'b0; end
              3'd2:    begin op = OP_WR_DATA; val = 8'h10; last = 1'b0; end
              3'd3:    begin op = OP_WR_CTRL; val = 8'h03; last = 1'b0; end
              3'd4:    begin op = OP_WR_DATA; val = 8'h51; last = 1'b0; end
              3'd5:    begin op = OP_WR_CTRL; val = 8'h05; last = 1'b0; end
              default: begin op = OP_WR_DATA; val = 8'hD1; end
            endcase
          end else begin
            case (idx)
              3'd0:    begin op = OP_WR_DATA; val = 8'h89; last = 1'b0; end
              3'd1:    begin op = OP_WR_CTRL; val = 8'h01; last = 1'b0; end
              3'd2:    begin op = OP_WR_CTRL; val = 8'h23; last = 1'b0; end
              default: begin op = OP_WR_CTRL; val = 8'h21; end
            endcase
          end
        end
        SEC_BODY: begin
          if (mode == MODE_NIB) begin
            case (idx)
              3'd0:    begin op = OP_WR_CTRL; val = {6'd0, 1'b1, ph}; last = 1'b0; end
              3'd1:    begin op = OP_RD_STAT; last = 1'b0; end
              3'd2:    begin op = OP_WR_CTRL; val = {5'd0, 1'b1, 1'b0, ph}; last = 1'b0; end
              default: begin op = OP_RD_STAT; end
            endcase
          end else if (mode == MODE_53) begin
            case (idx)
              3'd0:    begin op = OP_WR_CTRL; val = {5'd0, 1'b1, 1'b0, ph}; last = 1'b0; end
              default: begin op = OP_RD_PAIR; end
            endcase
          end else begin
            case (idx)
              3'd0:    begin op = OP_WR_CTRL; val = {7'b0010010, ph}; last = 1'b0; end
              default: begin op = OP_RD_DATA; end
            endcase
          end
        end
        default: begin
          if (wide) begin
            op = OP_WR_CTRL; val = 8'h04;
          end else if (mode == MODE_BYTE) begin
            case (idx)
              3'd0:    begin op = OP_WR_CTRL; val = 8'h06; last = 1'b0; end
              default: begin op = OP_WR_CTRL; val = 8'h04; end
            endcase
          end else begin
            case (idx)
              3'd0:    begin op = OP_WR_DATA; val = 8'h00; last = 1'b0; end
              default: begin op = OP_WR_CTRL; val = 8'h04; end
            endcase
          end
        end
      endcase
    end else begin
      unique case (sec)
        SEC_PRE: begin
          if (wide) begin
            op = OP_WR_ADDR; val = 8'h40;
          end else begin
            case (idx)
              3'd0:    begin op = OP_WR_DATA; val = 8'hA1; last = 1'b0; end
              3'd1:    begin op = OP_WR_CTRL; val = 8'h01; last = 1'b0; end
              3'd2:    begin op = OP_WR_CTRL; val = 8'h03; last = 1'b0; end
              3'd3:    begin op = OP_WR_CTRL; val = 8'h01; last = 1'b0; end
              default: begin op = OP_WR_CTRL; val = 8'h05; end
            endcase
          end
        end
        SEC_POST: begin
          if (wide) begin
            empty = 1'b1;
          end else begin
            case (idx)
              3'd0:    begin op = OP_WR_CTRL; val = 8'h07; last = 1'b0; end
              default: begin op = OP_WR_CTRL; val = 8'h04; end
            endcase
          end
        end
        default: empty = 1'b1;
      endcase
    end
  end

endmodule

// File: rtl/bte_codec.sv
// Rebuilds one byte from the samples of a legacy read slot.
module bte_codec
  import bte_pkg::*;
(
  input  logic [2:0] mode,
  input  logic [7:0] samp_a,
  input  logic [7:0] samp_b,
  output logic [7:0] byte_out
);

  always_comb begin
    case (mode)
      MODE_NIB: byte_out = {samp_b[7:4], samp_a[7:4]};
      MODE_53:  byte_out = {samp_b[3:1], samp_a[7:3]};
      default:  byte_out = samp_a;
    endcase
  end

endmodule

// File: rtl/bte_lane.sv
// Byte-lane packer/unpacker for wide data-cycle units, low lane first.
module bte_lane #(
  parameter  int WORD_BYTES = 4,
  localparam int LANE_W     = (WORD_BYTES > 1) ? $clog2(WORD_BYTES) : 1,
  localparam int WORD_W     = 8 * WORD_BYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic [LANE_W-1:0] last_lane,
  input  logic              push,
  input  logic [7:0]        byte_in,
  input  logic              load,
  input  logic [WORD_W-1:0] word_in,
  input  logic              adv,
  output logic [7:0]        byte_out,
  output logic [WORD_W-1:0] word_out,
  output logic              at_last
);

  logic [LANE_W-1:0] lane_q;
  logic [WORD_W-1:0] word_q;

  assign at_last  = (lane_q == last_lane);
  assign byte_out = word_q[{lane_q, 3'b000} +: 8];

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      lane_q <= '0;
      if (!rst_n) word_q <= '0;
    end else if (load) begin
      word_q <= word_in;
      lane_q <= '0;
    end else if (push) begin
      word_q[{lane_q, 3'b000} +: 8] <= byte_in;
      lane_q <= at_last ? '0 : lane_q + 1'b1;
    end else if (adv) begin
      lane_q <= at_last ? '0 : lane_q + 1'b1;
    end
  end

  for (genvar g = 0; g < WORD_BYTES; g++) begin : g_mask
    assign word_out[g*8 +: 8] = (LANE_W'(g) <= last_lane) ? word_q[g*8 +: 8] : 8'h00;
  end

endmodule

// File: rtl/bte_top.sv
module bte_top
  import bte_pkg::*;
#(
  parameter  int          CNT_W      = 16,
  parameter  int          WORD_BYTES = 4,
  parameter  int          BLK_THRESH = 512,
  parameter  logic [7:0]  SIZE_REG   = 8'h84,
  localparam int          WORD_W     = 8 * WORD_BYTES,
  localparam int          LANE_W     = (WORD_BYTES > 1) ? $clog2(WORD_BYTES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              dir_wr,
  input  logic [2:0]        mode,
  input  logic [CNT_W-1:0]  count,
  output logic              done,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [7:0]        wr_data,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [7:0]        rd_data,
  output logic [3:0]        port_op,
  output logic [WORD_W-1:0] port_val,
  output logic [1:0]        port_size,
  input  logic [WORD_W-1:0] port_in_a,
  input  logic [7:0]        port_in_b,
  output logic              cfg_valid,
  input  logic              cfg_ready,
  output logic [7:0]        cfg_addr,
  output logic [7:0]        cfg_data
);

  typedef enum logic [3:0] {
    S_IDLE, S_REGPRE, S_PRE, S_BODY, S_EMIT, S_WGET, S_WDATA, S_WSTB,
    S_EGET, S_EPUT, S_ERD, S_EOUT, S_POST, S_REGPOST, S_DONE
  } st_e;

  st_e              st_q;
  logic [2:0]       mode_q;
  logic             wr_q;
  logic [CNT_W-1:0] count_q;
  logic [CNT_W-1:0] left_q;
  logic [2:0]       idx_q;
  logic             ph_q;
  logic [7:0]       a_q, b_q, byte_q, last_q;
  logic             last_vld_q;

  // ---- derived control ----
  logic     wide;
  logic     post_reg;
  logic     start_ok, start_pre_reg;
  logic [1:0] start_shift;
  st_e      post_st, body_st;
  logic     unit_last;

  assign wide          = (mode_q >= MODE_W8);
  assign post_reg      = wide && (!wr_q || (int'(count_q) < BLK_THRESH));
  assign start_ok      = start && (mode <= MODE_W32);
  assign start_pre_reg = (mode >= MODE_W8) &&
                         (dir_wr ? (int'(count) < BLK_THRESH) : (int'(count) > BLK_THRESH));
  assign start_shift   = (mode == MODE_W16) ? 2'd1 : (mode == MODE_W32) ? 2'd2 : 2'd0;
  assign unit_last     = (left_q == CNT_W'(1));

  always_comb begin
    if (!wide || !wr_q)  post_st = S_POST;
    else if (post_reg)   post_st = S_REGPOST;
    else                 post_st = S_DONE;
    if (left_q == '0)    body_st = post_st;
    else if (wide)       body_st = wr_q ? S_EGET : S_ERD;
    else                 body_st = wr_q ? S_WGET : S_BODY;
  end

  // ---- script lookup ----
  section_e sec;
  port_op_e s_op;
  logic [7:0] s_val;
  logic     s_last, s_empty;

  assign sec = (st_q == S_PRE) ? SEC_PRE : (st_q == S_POST) ? SEC_POST : SEC_BODY;

  bte_script u_script (
    .mode  (mode_q),
    .wr    (wr_q),
    .sec   (sec),
    .idx   (idx_q),
    .ph    (ph_q),
    .op    (s_op),
    .val   (s_val),
    .last  (s_last),
    .empty (s_empty)
  );

  // ---- legacy byte assembly ----
  logic [7:0] codec_byte;

  bte_codec u_codec (
    .mode     (mode_q),
    .samp_a   (a_q),
    .samp_b   (b_q),
    .byte_out (codec_byte)
  );

  // ---- wide unit lanes ----
  logic [LANE_W-1:0] last_lane;
  logic              ln_push, ln_load, ln_adv, ln_last;
  logic [7:0]        ln_byte;
  logic [WORD_W-1:0] ln_word;

  always_comb begin
    if (mode_q == MODE_W16)      last_lane = LANE_W'(1);
    else if (mode_q == MODE_W32) last_lane = LANE_W'(3);
    else                         last_lane = '0;
  end

  assign ln_push = (st_q == S_EGET) && wr_valid;
  assign ln_load = (st_q == S_ERD);
  assign ln_adv  = (st_q == S_EOUT) && rd_ready;

  bte_lane #(.WORD_BYTES(WORD_BYTES)) u_lane (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (start_ok && st_q == S_IDLE),
    .last_lane (last_lane),
    .push      (ln_push),
    .byte_in   (wr_data),
    .load      (ln_load),
    .word_in   (port_in_a),
    .adv       (ln_adv),
    .byte_out  (ln_byte),
    .word_out  (ln_word),
    .at_last   (ln_last)
  );

  // ---- sequencing ----
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q       <= S_IDLE;
      mode_q     <= '0;
      wr_q       <= 1'b0;
      count_q    <= '0;
      left_q     <= '0;
      idx_q      <= '0;
      ph_q       <= 1'b0;
      a_q        <= '0;
      b_q        <= '0;
      byte_q     <= '0;
      last_q     <= '0;
      last_vld_q <= 1'b0;
    end else begin
      unique case (st_q)
        S_IDLE: if (start_ok) begin
          mode_q     <= mode;
          wr_q       <= dir_wr;
          count_q    <= count;
          left_q     <= count >> start_shift;
          idx_q      <= '0;
          ph_q       <= !dir_wr;
          last_vld_q <= 1'b0;
          st_q       <= start_pre_reg ? S_REGPRE : S_PRE;
        end
        S_REGPRE: if (cfg_ready) st_q <= S_PRE;
        S_PRE: begin
          if (s_last) begin
            idx_q <= '0;
            st_q  <= body_st;
          end else idx_q <= idx_q + 3'd1;
        end
        S_BODY: begin
          if (s_op == OP_RD_STAT && idx_q == 3'd1) a_q <= port_in_a[7:0];
          if (s_op == OP_RD_STAT && idx_q == 3'd3) b_q <= port_in_a[7:0];
          if (s_op == OP_RD_PAIR) begin
            a_q <= port_in_a[7:0];
            b_q <= port_in_b;
          end
          if (s_op == OP_RD_DATA) a_q <= port_in_a[7:0];
          if (s_last) begin
            idx_q <= '0;
            st_q  <= S_EMIT;
          end else idx_q <= idx_q + 3'd1;
        end
        S_EMIT: if (rd_ready) begin
          ph_q   <= !ph_q;
          left_q <= left_q - 1'b1;
          st_q   <= unit_last ? post_st : S_BODY;
        end
        S_WGET: if (wr_valid) begin
          byte_q <= wr_data;
          st_q   <= (last_vld_q && wr_data == last_q) ? S_WSTB : S_WDATA;
        end
        S_WDATA: begin
          last_q     <= byte_q;
          last_vld_q <= 1'b1;
          st_q       <= S_WSTB;
        end
        S_WSTB: begin
          ph_q   <= !ph_q;
          left_q <= left_q - 1'b1;
          st_q   <= unit_last ? post_st : S_WGET;
        end
        S_EGET: if (wr_valid && ln_last) st_q <= S_EPUT;
        S_EPUT: begin
          left_q <= left_q - 1'b1;
          st_q   <= unit_last ? post_st : S_EGET;
        end
        S_ERD: st_q <= S_EOUT;
        S_EOUT: if (rd_ready && ln_last) begin
          left_q <= left_q - 1'b1;
          st_q   <= unit_last ? post_st : S_ERD;
        end
        S_POST: begin
          if (s_last || s_empty) begin
            idx_q <= '0;
            st_q  <= post_reg ? S_REGPOST : S_DONE;
          end else idx_q <= idx_q + 3'd1;
        end
        S_REGPOST: if (cfg_ready) st_q <= S_DONE;
        S_DONE:    st_q <= S_IDLE;
        default:   st_q <= S_IDLE;
      endcase
    end
  end

  // ---- outputs ----
  port_op_e op_c;

  always_comb begin
    op_c      = OP_NONE;
    port_val  = '0;
    port_size = 2'd0;
    rd_valid  = 1'b0;
    rd_data   = 8'h00;
    wr_ready  = 1'b0;
    cfg_valid = 1'b0;
    cfg_data  = 8'h00;
    done      = 1'b0;
    unique case (st_q)
      S_REGPRE: begin
        cfg_valid = 1'b1;
        cfg_data  = wr_q ? 8'd1 : 8'd3;
      end
      S_PRE, S_BODY, S_POST: begin
        op_c = s_empty ? OP_NONE : s_op;
        if (!s_empty) port_val = WORD_W'(s_val);
      end
      S_EMIT: begin
        rd_valid = 1'b1;
        rd_data  = codec_byte;
      end
      S_WGET, S_EGET: wr_ready = 1'b1;
      S_WDATA: begin
        op_c     = OP_WR_DATA;
        port_val = WORD_W'(byte_q);
      end
      S_WSTB: begin
        op_c     = OP_WR_CTRL;
        port_val = WORD_W'({5'd0, 1'b1, 1'b0, ph_q});
      end
      S_EPUT: begin
        op_c      = OP_WR_EPP;
        port_val  = ln_word;
        port_size = 2'(mode_q - MODE_W8);
      end
      S_ERD: begin
        op_c      = OP_RD_EPP;
        port_size = 2'(mode_q - MODE_W8);
      end
      S_EOUT: begin
        rd_valid = 1'b1;
        rd_data  = ln_byte;
      end
      S_REGPOST: cfg_valid = 1'b1;
      S_DONE:    done = 1'b1;
      default: ;
    endcase
  end

  assign port_op  = op_c;
  assign cfg_addr = SIZE_REG;

endmodule

// File: rtl/bte_checks.sv
module bte_checks #(
  parameter logic [7:0] SIZE_REG = 8'h84
) (
  input logic       clk,
  input logic       rst_n,
  input logic       done,
  input logic       wr_ready,
  input logic       rd_valid,
  input logic       rd_ready,
  input logic [7:0] rd_data,
  input logic [3:0] port_op,
  input logic       cfg_valid,
  input logic       cfg_ready,
  input logic [7:0] cfg_addr,
  input logic [7:0] cfg_data
);

  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (port_op == 4'd0 && !cfg_valid && !rd_valid && !wr_ready));

  p_rd_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));

  p_cfg_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_valid && !cfg_ready) |=> (cfg_valid && $stable(cfg_data)));

  p_cfg_target_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_valid |-> (cfg_addr == SIZE_REG));

  p_cfg_noop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_valid |-> (port_op == 4'd0));

  p_stream_side_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_valid && wr_ready));

  p_stream_noop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid || wr_ready) |-> (port_op == 4'd0));

  p_op_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    port_op <= 4'd8);

endmodule

bind bte_top bte_checks #(.SIZE_REG(SIZE_REG)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .done      (done),
  .wr_ready  (wr_ready),
  .rd_valid  (rd_valid),
  .rd_ready  (rd_ready),
  .rd_data   (rd_data),
  .port_op   (port_op),
  .cfg_valid (cfg_valid),
  .cfg_ready (cfg_ready),
  .cfg_addr  (cfg_addr),
  .cfg_data  (cfg_data)
);

// File: tb/sim_bte_top.sv
module sim_bte_top;

  localparam int CNT_W = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        dir_wr = 1'b0;
  logic [2:0]  mode_in = 3'd0;
  logic [15:0] count_in = '0;
  logic        done;
  logic        wr_valid, wr_ready;
  logic [7:0]  wr_data;
  logic        rd_valid, rd_ready;
  logic [7:0]  rd_data;
  logic [3:0]  port_op;
  logic [31:0] port_val;
  logic [1:0]  port_size;
  logic [31:0] port_in_a;
  logic [7:0]  port_in_b;
  logic        cfg_valid, cfg_ready;
  logic [7:0]  cfg_addr, cfg_data;

  always #5 clk = ~clk;

  bte_top u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .dir_wr(dir_wr), .mode(mode_in),
    .count(count_in), .done(done), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_data(wr_data), .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .port_op(port_op), .port_val(port_val), .port_size(port_size),
    .port_in_a(port_in_a), .port_in_b(port_in_b), .cfg_valid(cfg_valid),
    .cfg_ready(cfg_ready), .cfg_addr(cfg_addr), .cfg_data(cfg_data)
  );

  int n_total = 0;
  int n_fail  = 0;
  int cyc = 0;
  int rd_cnt = 0;
  bit stall_en = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [31:0] pat(input int n);
    return 32'(n) * 32'h01F3_5A27 + 32'h1357_9BDF;
  endfunction

  // port model: read data depends on how many reads have been issued
  logic [31:0] pa;
  assign pa        = pat(rd_cnt);
  assign port_in_a = pa;
  assign port_in_b = pa[15:8] ^ 8'hA5;
  always @(posedge clk)
    if (port_op >= 4'd5 && port_op <= 4'd8) rd_cnt <= rd_cnt + 1;

  // byte source
  logic [7:0] src_mem [2048];
  int src_len = 0;
  int src_idx = 0;
  int src_wr  = 0;
  assign wr_valid = (src_idx < src_len) && (!stall_en || !cyc[1]);
  assign wr_data  = src_mem[src_idx[10:0]];
  always @(posedge clk) if (wr_valid && wr_ready) src_idx <= src_idx + 1;

  assign rd_ready  = !stall_en || cyc[0];
  assign cfg_ready = !stall_en || cyc[1];

  // monitor
  logic [37:0] trace_q[$];
  logic [37:0] exp_q[$];
  logic [7:0]  got_q[$];
  logic [7:0]  expb_q[$];
  int done_cnt = 0;

  always @(negedge clk) begin
    if (port_op != 4'd0) trace_q.push_back({port_op, port_size, port_val});
    if (cfg_valid && cfg_ready) trace_q.push_back({4'hF, 2'd0, 16'd0, cfg_addr, cfg_data});
    if (rd_valid && rd_ready) got_q.push_back(rd_data);
    if (done) done_cnt <= done_cnt + 1;
  end

  task automatic ck(input string tag, input bit ok, input logic [63:0] act, input logic [63:0] expv);
    n_total++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic ex(input logic [3:0] op, input logic [31:0] v, input logic [1:0] sz);
    exp_q.push_back({op, sz, v});
  endtask

  task automatic excf(input logic [7:0] d);
    exp_q.push_back({4'hF, 2'd0, 16'd0, 8'h84, d});
  endtask

  task automatic check_trace(input string tag);
    int bad = -1;
    if (trace_q.size() != exp_q.size()) begin
      ck({tag, " trace length"}, 1'b0, 64'(trace_q.size()), 64'(exp_q.size()));
      return;
    end
    for (int i = 0; i < exp_q.size(); i++)
      if (bad < 0 && trace_q[i] != exp_q[i]) bad = i;
    if (bad >= 0) ck({tag, " trace entry"}, 1'b0, 64'(trace_q[bad]), 64'(exp_q[bad]));
    else ck(tag, 1'b1, 0, 0);
  endtask

  task automatic check_bytes(input string tag);
    int bad = -1;
    if (got_q.size() != expb_q.size()) begin
      ck({tag, " byte count"}, 1'b0, 64'(got_q.size()), 64'(expb_q.size()));
      return;
    end
    for (int i = 0; i < expb_q.size(); i++)
      if (bad < 0 && got_q[i] != expb_q[i]) bad = i;
    if (bad >= 0) ck({tag, " byte"}, 1'b0, 64'(got_q[bad]), 64'(expb_q[bad]));
    else ck(tag, 1'b1, 0, 0);
  endtask

  task automatic load_src(input logic [7:0] b);
    src_mem[src_wr[10:0]] = b;
    src_wr++;
  endtask

  task automatic run(input logic [2:0] m, input logic w, input int c, input bit poke, input string tag);
    int d0 = done_cnt;
    trace_q.delete();
    got_q.delete();
    src_len = src_wr;
    @(negedge clk);
    mode_in = m; dir_wr = w; count_in = 16'(c); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      repeat (3) @(negedge clk);
      mode_in = 3'd2; dir_wr = ~w; count_in = 16'd5; start = 1'b1;
      @(negedge clk);
      start = 1'b0; mode_in = m; dir_wr = w; count_in = 16'(c);
    end
    while (done_cnt == d0) @(negedge clk);
    repeat (4) @(negedge clk);
    ck({tag, " single done"}, (done_cnt - d0) == 1, 64'(done_cnt - d0), 1);
  endtask

  // R3: nibble read
  task automatic t_nibble();
    int base = rd_cnt;
    logic ph = 1'b1;
    exp_q.delete(); expb_q.delete();
    ex(1, 32'h81, 0); ex(2, 32'h01, 0); ex(2, 32'h03, 0); ex(1, 32'hC1, 0);
    for (int k = 0; k < 3; k++) begin
      logic [31:0] a = pat(base + 2*k);
      logic [31:0] b = pat(base + 2*k + 1);
      ex(2, 32'(2 + ph), 0); ex(5, 0, 0); ex(2, 32'(4 + ph), 0); ex(5, 0, 0);
      expb_q.push_back({b[7:4], a[7:4]});
      ph = ~ph;
    end
    ex(1, 0, 0); ex(2, 32'h04, 0);
    stall_en = 1'b1;
    run(3'd0, 1'b0, 3, 1'b0, "R11 nibble");
    stall_en = 1'b0;
    check_trace("R3 nibble sequence");
    check_bytes("R3 nibble data");
  endtask

  // R4 + R10: 5/3 read with sink stalls
  task automatic t_pair();
    int base = rd_cnt;
    logic ph = 1'b1;
    exp_q.delete(); expb_q.delete();
    ex(1, 32'h91, 0); ex(2, 32'h01, 0); ex(1, 32'h10, 0); ex(2, 32'h03, 0);
    ex(1, 32'h51, 0); ex(2, 32'h05, 0); ex(1, 32'hD1, 0);
    for (int k = 0; k < 4; k++) begin
      logic [31:0] a = pat(base + k);
      logic [7:0]  b = a[15:8] ^ 8'hA5;
      ex(2, 32'(4 + ph), 0); ex(6, 0, 0);
      expb_q.push_back({b[3:1], a[7:3]});
      ph = ~ph;
    end
    ex(1, 0, 0); ex(2, 32'h04, 0);
    stall_en = 1'b1;
    run(3'd1, 1'b0, 4, 1'b0, "R4 pair");
    stall_en = 1'b0;
    check_trace("R4 pair sequence");
    check_bytes("R10 pair data under stall");
  endtask

  // R5 + R12: byte read, start pulse mid-transfer ignored
  task automatic t_byte();
    int base = rd_cnt;
    logic ph = 1'b1;
    exp_q.delete(); expb_q.delete();
    ex(1, 32'h89, 0); ex(2, 32'h01, 0); ex(2, 32'h23, 0); ex(2, 32'h21, 0);
    for (int k = 0; k < 3; k++) begin
      logic [31:0] a = pat(base + k);
      ex(2, 32'(8'h24 + ph), 0); ex(7, 0, 0);
      expb_q.push_back(a[7:0]);
      ph = ~ph;
    end
    ex(2, 32'h06, 0); ex(2, 32'h04, 0);
    run(3'd2, 1'b0, 3, 1'b1, "R12 busy start");
    check_trace("R12 byte sequence with ignored start");
    check_bytes("R5 byte data");
  endtask

  // R13: zero count
  task automatic t_zero();
    exp_q.delete();
    ex(1, 32'h89, 0); ex(2, 32'h01, 0); ex(2, 32'h23, 0); ex(2, 32'h21, 0);
    ex(2, 32'h06, 0); ex(2, 32'h04, 0);
    run(3'd2, 1'b0, 0, 1'b0, "R13 zero");
    check_trace("R13 zero count sequence");
  endtask

  // R6: legacy writes with repeated bytes
  task automatic t_write(input logic [2:0] m, input bit st, input string tag);
    logic [7:0] d[6] = '{8'h11, 8'h11, 8'h22, 8'h22, 8'h22, 8'h11};
    logic ph = 1'b0;
    logic [8:0] last = 9'h100;
    exp_q.delete();
    ex(1, 32'hA1, 0); ex(2, 32'h01, 0); ex(2, 32'h03, 0); ex(2, 32'h01, 0); ex(2, 32'h05, 0);
    for (int k = 0; k < 6; k++) begin
      load_src(d[k]);
      if ({1'b0, d[k]} != last) begin
        ex(1, 32'(d[k]), 0);
        last = {1'b0, d[k]};
      end
      ex(2, 32'(4 + ph), 0);
      ph = ~ph;
    end
    ex(2, 32'h07, 0); ex(2, 32'h04, 0);
    stall_en = st;
    run(m, 1'b1, 6, 1'b0, "R6 write");
    stall_en = 1'b0;
    check_trace(tag);
  endtask

  // R7/R9: wide reads
  task automatic t_wide_rd(input logic [2:0] m, input int c, input bit st, input string tag);
    int base = rd_cnt;
    int nb = (m == 3'd4) ? 2 : (m == 3'd5) ? 4 : 1;
    int words = c / nb;
    exp_q.delete(); expb_q.delete();
    if (c > 512) excf(8'd3);
    ex(3, 32'h00, 0); ex(2, 32'h24, 0);
    for (int k = 0; k < words; k++) begin
      logic [31:0] v = pat(base + k);
      ex(8, 0, 2'(m - 3));
      for (int j = 0; j < nb; j++) expb_q.push_back(v[j*8 +: 8]);
    end
    ex(2, 32'h04, 0); excf(8'd0);
    stall_en = st;
    run(m, 1'b0, c, 1'b0, tag);
    stall_en = 1'b0;
    check_trace({tag, " sequence"});
    check_bytes({tag, " data"});
  endtask

  // R8/R9: wide writes
  task automatic t_wide_wr(input logic [2:0] m, input int c, input bit st, input string tag);
    int nb = (m == 3'd4) ? 2 : (m == 3'd5) ? 4 : 1;
    int words = c / nb;
    exp_q.delete();
    if (c < 512) excf(8'd1);
    ex(3, 32'h40, 0);
    for (int k = 0; k < words; k++) begin
      logic [31:0] v = '0;
      for (int j = 0; j < nb; j++) begin
        logic [7:0] b = 8'(k * 29 + j * 7 + 3);
        load_src(b);
        v[j*8 +: 8] = b;
      end
      ex(4, v, 2'(m - 3));
    end
    if (c < 512) excf(8'd0);
    stall_en = st;
    run(m, 1'b1, c, 1'b0, tag);
    stall_en = 1'b0;
    check_trace({tag, " sequence"});
  endtask

  // R12: illegal mode ignored
  task automatic t_badmode();
    int d0 = done_cnt;
    trace_q.delete();
    @(negedge clk);
    mode_in = 3'd6; dir_wr = 1'b0; count_in = 16'd4; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (20) @(negedge clk);
    ck("R12 mode 6 no operations", trace_q.size() == 0, 64'(trace_q.size()), 0);
    ck("R12 mode 6 no done", done_cnt == d0, 64'(done_cnt - d0), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_total++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    ck("R1 reset idle", port_op == 0 && !rd_valid && !wr_ready && !cfg_valid && !done,
       64'({port_op, rd_valid, wr_ready, cfg_valid, done}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_nibble();
    t_pair();
    t_byte();
    t_zero();
    t_write(3'd0, 1'b1, "R6 write mode 0 stalled");
    t_write(3'd1, 1'b0, "R6 write mode 1");
    t_wide_rd(3'd3, 600, 1'b0, "R7 8-bit read over threshold");
    t_wide_rd(3'd4, 6, 1'b1, "R9 16-bit read");
    t_wide_rd(3'd5, 9, 1'b0, "R9 32-bit read");
    t_wide_wr(3'd4, 4, 1'b1, "R8 16-bit write under threshold");
    t_wide_wr(3'd5, 512, 1'b0, "R8 32-bit write at threshold");
    t_wide_wr(3'd3, 3, 1'b0, "R2 8-bit write");
    t_badmode();
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end

endmodule